// File: doc/BRIEF.md
# Ternary Cyclic Convolution Encryptor

This block forms the ciphertext of a lattice-based public-key scheme over the polynomial ring modulo x^N − 1. It computes e(x) = p·(r(x)·h(x)) + m(x) with every coefficient reduced modulo q. Because q is a power of two, the reduction costs nothing: each coefficient simply keeps its low log2(q) bits. The public key h sits in an on-chip bank of N coefficients. It is written once through an indexed write port and then serves any number of encryptions without being loaded again.

The ephemeral key r and the message m arrive as a stream of ternary codes, one coefficient pair per clock cycle, in index order. Every coefficient of r is −1, 0 or +1. On each step, each of the N accumulator lanes therefore adds its current h coefficient, subtracts it, or leaves its value unchanged, so no multiplier is needed. After each step the h bank rotates by one place. After N steps the bank has come back to its original alignment, and the accumulators hold the cyclic convolution. The factor p and the message are applied when a result is read out. The caller pulses a start, streams N pairs while busy is high, waits for done, and then reads each e coefficient through an indexed port with one cycle of latency.

Top module: `tern_conv_encryptor`

## Requirements
- R1: While reset is high and on the cycle after it, busy, done and rd_data are 0. Reset also clears the whole h bank to zero, so a run made before any key load yields e = m.
- R2: A write with h_we high, taken while busy is low, stores h_data as coefficient h_idx of the key.
- R3: Writes to h while busy is high are ignored. The key stays resident, so further runs without a reload use the same h.
- R4: A start pulse while busy is low clears the accumulators and raises busy on the next cycle. Busy then stays high for exactly N cycles, and one (r_code, m_code) pair is consumed in each of those cycles, starting with index 0. After that, done rises.
- R5: A start pulse while busy is high is ignored and does not shorten or restart the run.
- R6: r_code is decoded as 2'b00 → 0, 2'b01 → +1, 2'b11 → −1. The unused code 2'b10 acts as 0.
- R7: When done is high, coefficient i reads as (p·Σ_k r_k·h_((i−k) mod N) + m_i) mod q, with the defaults N = 251, p = 3 and q = 128 (7-bit results).
- R8: m_code uses the same ternary encoding as r_code, and m_i is added as a signed value.
- R9: rd_data shows the coefficient selected by rd_idx one cycle later. An index of N or more reads as 0.
- R10: Busy and done are never high together. Done stays high until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_we | input | 1 | Key coefficient write enable |
| h_idx | input | 8 | Key coefficient index |
| h_data | input | 7 | Key coefficient value |
| start | input | 1 | Begin an encryption run |
| r_code | input | 2 | Ternary code of the current ephemeral coefficient |
| m_code | input | 2 | Ternary code of the current message coefficient |
| busy | output | 1 | Run in progress; one coefficient pair consumed per cycle |
| done | output | 1 | Result ready for readout |
| rd_idx | input | 8 | Result coefficient index |
| rd_data | output | 7 | Result coefficient, registered |

## Verification
The assertions assume the caller asserts start only as a single-cycle pulse and keeps key writes to idle or done periods. They allow for the bench breaking that second assumption on purpose, because the design must ignore such writes. The checks on the run window assume that reset is not raised in the middle of a run. The bench raises reset only at the start. Between directed patterns (a single +1 tap, an all −1 key against maximal h, an unloaded key) it draws r, m and h from $urandom with a fixed seed, and it sprinkles the spare code 2'b10 into r and m. In one run it deliberately injects starts and key writes while busy is high, so that the ignore paths are exercised rather than assumed.

// File: rtl/tce_pkg.sv
package tce_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } tce_state_e;

  typedef enum logic [1:0] {
    OP_SKIP = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2
  } tce_op_e;

  // Ternary code: 01 -> +1, 11 -> -1, anything else -> 0
  function automatic tce_op_e decode_tern(input logic [1:0] code);
    case (code)
      2'b01:   return OP_ADD;
      2'b11:   return OP_SUB;
      default: return OP_SKIP;
    endcase
  endfunction

endpackage

// File: rtl/tce_ctrl.sv
module tce_ctrl #(
  parameter int N    = 251,
  parameter int IDXW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  output logic            busy,
  output logic            done,
  output logic            clr,
  output logic            step_en,
  output logic [IDXW-1:0] step_idx
);
  import tce_pkg::*;

  localparam logic [IDXW-1:0] LAST = IDXW'(N - 1);

  tce_state_e      state;
  logic [IDXW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_RUN: begin
          if (cnt == LAST) state <= ST_DONE;
          else             cnt   <= cnt + 1'b1;
        end
        default: begin
          if (start) begin
            state <= ST_RUN;
            cnt   <= '0;
          end
        end
      endcase
    end
  end

  assign busy     = (state == ST_RUN);
  assign done     = (state == ST_DONE);
  assign clr      = start && !busy;
  assign step_en  = busy;
  assign step_idx = cnt;

endmodule

// File: rtl/tce_h_ring.sv
module tce_h_ring #(
  parameter int N    = 251,
  parameter int QW   = 7,
  parameter int IDXW = $clog2(N)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rot_en,
  input  logic                   wr_en,
  input  logic [IDXW-1:0]        wr_idx,
  input  logic [QW-1:0]          wr_data,
  output logic [N-1:0][QW-1:0]   h_q
);

  // Rotation moves coefficient i to slot i+1 (mod N); after N steps the
  // bank is back in its loaded alignment, so the key stays resident.
  always_ff @(posedge clk) begin
    if (rst) begin
      h_q <= '0;
    end else if (rot_en) begin
      h_q <= {h_q[N-2:0], h_q[N-1]};
    end else if (wr_en && (int'(wr_idx) < N)) begin
      h_q[wr_idx] <= wr_data;
    end
  end

endmodule

// File: rtl/tce_acc_bank.sv
module tce_acc_bank #(
  parameter int N  = 251,
  parameter int QW = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 step_en,
  input  logic [1:0]           r_code,
  input  logic [N-1:0][QW-1:0] h_in,
  output logic [N-1:0][QW-1:0] acc_q
);
  import tce_pkg::*;

  tce_op_e op;
  assign op = decode_tern(r_code);

  // One lane per coefficient; wrap-around arithmetic is the mod-q step.
  for (genvar i = 0; i < N; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        acc_q[i] <= '0;
      end else if (step_en) begin
        case (op)
          OP_ADD:  acc_q[i] <= acc_q[i] + h_in[i];
          OP_SUB:  acc_q[i] <= acc_q[i] - h_in[i];
          default: acc_q[i] <= acc_q[i];
        endcase
      end
    end
  end

endmodule

// File: rtl/tce_readout.sv
module tce_readout #(
  parameter int N    = 251,
  parameter int QW   = 7,
  parameter int P    = 3,
  parameter int IDXW = $clog2(N)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 m_we,
  input  logic [IDXW-1:0]      m_idx,
  input  logic [1:0]           m_code,
  input  logic [N-1:0][QW-1:0] acc_in,
  input  logic [IDXW-1:0]      rd_idx,
  output logic [QW-1:0]        rd_data
);
  import tce_pkg::*;

  logic [1:0]    m_mem [N];
  logic          in_range;
  logic [QW-1:0] acc_sel;
  logic [QW-1:0] scaled;
  logic [QW-1:0] m_val;
  tce_op_e       m_op;

  always_ff @(posedge clk) begin
    if (m_we) m_mem[m_idx] <= m_code;
  end

  assign in_range = int'(rd_idx) < N;
  assign acc_sel  = in_range ? acc_in[rd_idx] : '0;
  assign m_op     = in_range ? decode_tern(m_mem[rd_idx]) : OP_SKIP;

  always_comb begin
    case (m_op)
      OP_ADD:  m_val = QW'(1);
      OP_SUB:  m_val = '1;
      default: m_val = '0;
    endcase
  end

  if (P == 3) begin : g_p3
    assign scaled = (acc_sel << 1) + acc_sel;
  end else begin : g_pgen
    assign scaled = QW'(acc_sel * P);
  end

  always_ff @(posedge clk) begin
    if (rst)           rd_data <= '0;
    else if (in_range) rd_data <= scaled + m_val;
    else               rd_data <= '0;
  end

endmodule

// File: rtl/tern_conv_encryptor.sv
module tern_conv_encryptor #(
  parameter int N    = 251,
  parameter int P    = 3,
  parameter int Q    = 128,
  parameter int QW   = $clog2(Q),
  parameter int IDXW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            h_we,
  input  logic [IDXW-1:0] h_idx,
  input  logic [QW-1:0]   h_data,
  input  logic            start,
  input  logic [1:0]      r_code,
  input  logic [1:0]      m_code,
  output logic            busy,
  output logic            done,
  input  logic [IDXW-1:0] rd_idx,
  output logic [QW-1:0]   rd_data
);

  logic                 clr;
  logic                 step_en;
  logic [IDXW-1:0]      step_idx;
  logic [N-1:0][QW-1:0] h_bank;
  logic [N-1:0][QW-1:0] acc;

  tce_ctrl #(.N(N), .IDXW(IDXW)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .busy(busy), .done(done), .clr(clr),
    .step_en(step_en), .step_idx(step_idx)
  );

  tce_h_ring #(.N(N), .QW(QW), .IDXW(IDXW)) u_ring (
    .clk(clk), .rst(rst), .rot_en(step_en),
    .wr_en(h_we && !busy), .wr_idx(h_idx), .wr_data(h_data),
    .h_q(h_bank)
  );

  tce_acc_bank #(.N(N), .QW(QW)) u_acc (
    .clk(clk), .rst(rst), .clr(clr), .step_en(step_en),
    .r_code(r_code), .h_in(h_bank), .acc_q(acc)
  );

  tce_readout #(.N(N), .QW(QW), .P(P), .IDXW(IDXW)) u_rd (
    .clk(clk), .rst(rst), .m_we(step_en), .m_idx(step_idx),
    .m_code(m_code), .acc_in(acc), .rd_idx(rd_idx), .rd_data(rd_data)
  );

endmodule

// File: rtl/tce_checker.sv
module tce_checker #(
  parameter int N    = 251,
  parameter int QW   = 7,
  parameter int IDXW = $clog2(N)
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic [IDXW-1:0] rd_idx,
  input logic [QW-1:0]   rd_data
);

  int busy_cnt;

  always_ff @(posedge clk) begin
    if (rst)       busy_cnt <= 0;
    else if (busy) busy_cnt <= busy_cnt + 1;
    else           busy_cnt <= 0;
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!busy && !done && rd_data == '0));

  assert_start_begins_R4: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && !done));

  assert_run_length_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (busy_cnt == N && done));

  assert_start_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && busy_cnt < N - 1) |=> busy);

  assert_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  assert_done_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

  assert_oob_read_R9: assert property (@(posedge clk) disable iff (rst)
    (int'(rd_idx) >= N) |=> (rd_data == '0));

endmodule

bind tern_conv_encryptor tce_checker #(.N(N), .QW(QW), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .rd_idx(rd_idx), .rd_data(rd_data)
);

// File: tb/tern_conv_encryptor_test.sv
module tern_conv_encryptor_test;

  localparam int N    = 251;
  localparam int Q    = 128;
  localparam int QW   = 7;
  localparam int IDXW = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            h_we = 1'b0;
  logic [IDXW-1:0] h_idx = '0;
  logic [QW-1:0]   h_data = '0;
  logic            start = 1'b0;
  logic [1:0]      r_code = '0;
  logic [1:0]      m_code = '0;
  logic            busy;
  logic            done;
  logic [IDXW-1:0] rd_idx = '0;
  logic [QW-1:0]   rd_data;

  int compared = 0;
  int mismatched = 0;
  int h_ref [N];
  logic [1:0] rc [N];
  logic [1:0] mc [N];

  always #5 clk = ~clk;

  tern_conv_encryptor uut (
    .clk(clk), .rst(rst), .h_we(h_we), .h_idx(h_idx), .h_data(h_data),
    .start(start), .r_code(r_code), .m_code(m_code),
    .busy(busy), .done(done), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  function automatic int tern(input logic [1:0] c);
    if (c == 2'b01) return 1;
    if (c == 2'b11) return -1;
    return 0;
  endfunction

  function automatic int expect_e(input int i);
    int s = 0;
    for (int k = 0; k < N; k++) s += tern(rc[k]) * h_ref[(i - k + N) % N];
    return (3 * s + tern(mc[i])) & (Q - 1);
  endfunction

  task automatic chk(input int act, input int exp, input string tag);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic load_h();
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      h_we = 1'b1; h_idx = IDXW'(i); h_data = QW'(h_ref[i]);
    end
    @(negedge clk);
    h_we = 1'b0;
  endtask

  task automatic run(input bit disturb);
    int bc = 0;
    @(negedge clk);
    start = 1'b1;
    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      if (busy) bc++;
      r_code = rc[k]; m_code = mc[k];
      if (disturb && (k % 50 == 7)) begin
        start = 1'b1; h_we = 1'b1; h_idx = IDXW'(k); h_data = QW'($urandom);
      end else begin
        start = 1'b0; h_we = 1'b0;
      end
    end
    @(negedge clk);
    start = 1'b0; h_we = 1'b0;
    chk(bc, N, "R4 busy cycles");
    chk(int'(done), 1, "R4 done after run");
    chk(int'(busy), 0, "R10 busy low when done");
  endtask

  task automatic readout(input string tag);
    int bad = 0;
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      rd_idx = IDXW'(i);
      @(negedge clk);
      compared++;
      if (int'(rd_data) != expect_e(i)) begin
        mismatched++; bad++;
        if (bad < 5)
          $display("FAIL %s idx=%0d actual=%0d expected=%0d", tag, i, rd_data, expect_e(i));
      end
    end
    chk(int'(done), 1, "R10 done holds through readout");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(int'(busy), 0, "R1 busy in reset");
    chk(int'(done), 0, "R1 done in reset");
    chk(int'(rd_data), 0, "R1 rd_data in reset");
    rst = 1'b0;
    @(negedge clk);
    chk(int'(busy), 0, "R1 busy after reset");

    // R1/R7/R8: unloaded key gives e = m
    for (int i = 0; i < N; i++) begin
      h_ref[i] = 0; rc[i] = 2'($urandom); mc[i] = 2'($urandom);
    end
    run(1'b0);
    readout("R1 R8 unloaded key");

    // R2/R6: single +1 tap at index 0 gives 3h + m
    for (int i = 0; i < N; i++) begin
      h_ref[i] = int'($urandom) & (Q - 1); rc[i] = 2'b00; mc[i] = 2'($urandom);
    end
    rc[0] = 2'b01;
    load_h();
    run(1'b0);
    readout("R2 R6 single tap");

    // R6/R7: random r with spare code 10 mixed in
    for (int i = 0; i < N; i++) begin
      rc[i] = 2'($urandom); mc[i] = 2'($urandom);
    end
    run(1'b0);
    readout("R7 random");

    // R7 corner: maximal key, all -1 ephemeral, all +1 message
    for (int i = 0; i < N; i++) begin
      h_ref[i] = Q - 1; rc[i] = 2'b11; mc[i] = 2'b01;
    end
    load_h();
    run(1'b0);
    readout("R7 max key all minus one");

    // R3/R5: starts and key writes injected while busy; key stays resident
    for (int i = 0; i < N; i++) begin
      rc[i] = 2'($urandom); mc[i] = 2'($urandom);
    end
    run(1'b1);
    readout("R3 R5 disturbed run");
    run(1'b0);
    readout("R3 resident key rerun");

    // R9: out-of-range reads give 0
    @(negedge clk); rd_idx = IDXW'(N);
    @(negedge clk); chk(int'(rd_data), 0, "R9 index N");
    rd_idx = '1;
    @(negedge clk); chk(int'(rd_data), 0, "R9 top index");

    // R10: start from done clears done
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(int'(done), 0, "R10 done cleared by start");
    chk(int'(busy), 1, "R4 busy after restart");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule